// File: doc/BRIEF.md
# General purpose timer channel

A single 16-bit timer channel reached through a small register bus that carries 16-bit reads and writes. The bus has three registers: a compare register, a directly writable up counter, and a setup register. A power-of-two prescaler divides one of two timer clock sources, which arrive as single-cycle enable pulses. The counter advances once for each prescaled tick. When the counter meets the compare condition, an event flag is raised. In greater-or-equal interrupt mode, a level interrupt follows that flag.

The setup register is split into two parts. The configuration field in bits 11:0 can be written exactly once after reset: the first write to the setup register latches it and sets a lock indicator. The enable bit and the two event flags stay writable for the whole run. A typical re-arm sequence from software has three steps: load the compare value, write the counter to 0, then write the setup register with the enable bit set and the event flag cleared. The interrupt handler stops the channel and clears the flags with a single setup write of 0x6000.

Top module: `tmr_channel`

## Requirements
- R1: After reset, the compare register, the counter and the setup register all read 0, and irq_o is 0.
- R2: A write to offset 0xA sets the compare register and a write to offset 0xC sets the counter. Both read back at the same offsets, and any other offset reads 0. A read is requested in one cycle and rdata_o shows the value after the next clock edge. A counter write takes precedence over an increment in the same cycle.
- R3: The first write to offset 0xE after reset latches bits 11:0 of the write data as the configuration. From then on, setup bit 12 reads 1.
- R4: Once bit 12 is set, setup writes leave bits 11:0 unchanged.
- R5: Setup bit 15 is the run enable and follows every setup write. While it is 0 the counter holds its value.
- R6: The counter advances once every 2^S ticks of the selected source, where S is setup bits 3:0. Bit 4 selects the source: 0 selects slow_tick_i and 1 selects fast_tick_i.
- R7: The counter wraps from 0xFFFF to 0x0000.
- R8: Setup bits 9:8 choose the compare mode. The value 00 means no event, 01 means the counter equals the compare value, and 10 or 11 mean the counter is greater than or equal to it. While the channel is enabled and the condition holds, setup bit 14 (the compare flag) is set.
- R9: irq_o is 1 exactly while bit 14 is set and the mode is 11. It stays high until the flag is cleared.
- R10: Bits 14 and 13 are cleared by writing 1. Writing 0 leaves them unchanged. A clear in the same cycle as a new event wins. Bit 13 is never set by this channel.
- R11: A setup write of 0x6000 clears both flags and stops the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| slow_tick_i | input | 1 | Slow timer source enable pulse |
| fast_tick_i | input | 1 | Fast timer source enable pulse |
| irq_o | output | 1 | Level interrupt for the compare event |

## Verification
The bench targets four corner cases:
- A second setup write carrying a different configuration. A design without a working lock would change the prescale or mode, and the counter would then run at the wrong rate.
- A counter preset to 0xFFFE so that it wraps. A design that saturates or overflows into a wider register would read back the wrong value.
- Flag writes of 0 while an event is pending, and a clear issued while the greater-or-equal condition still holds with the channel stopped. A design with the priority reversed would leave irq_o stuck high.
- Modes 00 and 10. A design that ignored the mode field would raise a flag, or the interrupt, where neither is due.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFF_CMP2  = 4'hA;
  localparam int unsigned OFF_CNT   = 4'hC;
  localparam int unsigned OFF_SETUP = 4'hE;

  localparam int unsigned CFG_W     = 12;
  localparam int unsigned SCALE_W   = 4;
  localparam int unsigned BIT_FAST  = 4;
  localparam int unsigned BIT_MODE  = 8;
  localparam int unsigned BIT_LOCK  = 12;
  localparam int unsigned BIT_F1    = 13;
  localparam int unsigned BIT_F2    = 14;
  localparam int unsigned BIT_EN    = 15;

  typedef enum logic [1:0] {
    CMP_OFF    = 2'b00,
    CMP_EQ     = 2'b01,
    CMP_GE     = 2'b10,
    CMP_GE_IRQ = 2'b11
  } cmp_mode_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRE_W   = 15,
  parameter int unsigned SCALE_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               sel_fast_i,
  input  logic               slow_tick_i,
  input  logic               fast_tick_i,
  input  logic [SCALE_W-1:0] scale_i,
  output logic               tick_o
);
  logic [PRE_W-1:0] pre_q, mask;
  logic             src;

  assign src    = sel_fast_i ? fast_tick_i : slow_tick_i;
  assign mask   = ~({PRE_W{1'b1}} << scale_i);
  assign tick_o = en_i & src & ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pre_q <= '0;
    else if (!en_i) pre_q <= '0;
    else if (src)   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_setup_reg.sv
module tmr_setup_reg
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             ev2_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             locked_o,
  output logic             en_o,
  output logic             f1_o,
  output logic             f2_o
);
  logic clr1, clr2;
  assign clr1 = wr_i & wdata_i[BIT_F1];
  assign clr2 = wr_i & wdata_i[BIT_F2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o    <= '0;
      locked_o <= 1'b0;
      en_o     <= 1'b0;
      f1_o     <= 1'b0;
      f2_o     <= 1'b0;
    end else begin
      if (wr_i && !locked_o) begin
        cfg_o    <= wdata_i[CFG_W-1:0];
        locked_o <= 1'b1;
      end
      if (wr_i) en_o <= wdata_i[BIT_EN];
      if (clr1) f1_o <= 1'b0;
      // clear wins over a same-cycle event
      if (clr2)       f2_o <= 1'b0;
      else if (ev2_i) f2_o <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_wr_i,
  input  logic          cmp_wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          tick_i,
  input  logic          en_i,
  input  cmp_mode_e     mode_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] cmp_o,
  output logic          ev_o
);
  logic hit;

  always_comb begin
    unique case (mode_i)
      CMP_EQ:             hit = (cnt_o == cmp_o);
      CMP_GE, CMP_GE_IRQ: hit = (cnt_o >= cmp_o);
      default:            hit = 1'b0;
    endcase
  end
  assign ev_o = en_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      cmp_o <= '0;
    end else begin
      if (cmp_wr_i)    cmp_o <= wdata_i;
      if (cnt_wr_i)    cnt_o <= wdata_i;
      else if (tick_i) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 4,
  parameter int unsigned PRE_W = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          slow_tick_i,
  input  logic          fast_tick_i,
  output logic          irq_o
);
  logic             wr, rd, sel_cmp, sel_cnt, sel_set;
  logic [CFG_W-1:0] cfg_q;
  logic             locked_q, en_q, f1_q, f2_q, tick, ev2;
  logic [DW-1:0]    cnt_q, cmp_q, setup_rd, rd_mux;
  cmp_mode_e        mode;

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign sel_cmp = (addr_i == AW'(OFF_CMP2));
  assign sel_cnt = (addr_i == AW'(OFF_CNT));
  assign sel_set = (addr_i == AW'(OFF_SETUP));
  assign mode    = cmp_mode_e'(cfg_q[BIT_MODE +: 2]);

  tmr_setup_reg #(.DW(DW)) i_setup (
    .clk_i, .rst_ni,
    .wr_i    (wr & sel_set),
    .wdata_i,
    .ev2_i   (ev2),
    .cfg_o   (cfg_q),
    .locked_o(locked_q),
    .en_o    (en_q),
    .f1_o    (f1_q),
    .f2_o    (f2_q)
  );

  tmr_prescaler #(.PRE_W(PRE_W), .SCALE_W(SCALE_W)) i_pre (
    .clk_i, .rst_ni,
    .en_i       (en_q),
    .sel_fast_i (cfg_q[BIT_FAST]),
    .slow_tick_i,
    .fast_tick_i,
    .scale_i    (cfg_q[SCALE_W-1:0]),
    .tick_o     (tick)
  );

  tmr_counter #(.DW(DW)) i_cnt (
    .clk_i, .rst_ni,
    .cnt_wr_i (wr & sel_cnt),
    .cmp_wr_i (wr & sel_cmp),
    .wdata_i,
    .tick_i   (tick),
    .en_i     (en_q),
    .mode_i   (mode),
    .cnt_o    (cnt_q),
    .cmp_o    (cmp_q),
    .ev_o     (ev2)
  );

  always_comb begin
    setup_rd            = '0;
    setup_rd[CFG_W-1:0] = cfg_q;
    setup_rd[BIT_LOCK]  = locked_q;
    setup_rd[BIT_F1]    = f1_q;
    setup_rd[BIT_F2]    = f2_q;
    setup_rd[BIT_EN]    = en_q;
    if (sel_cmp)      rd_mux = cmp_q;
    else if (sel_cnt) rd_mux = cnt_q;
    else if (sel_set) rd_mux = setup_rd;
    else              rd_mux = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end

  assign irq_o = f2_q & (mode == CMP_GE_IRQ);
endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 4,
  parameter int unsigned CFG_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [AW-1:0]    addr_i,
  input logic [DW-1:0]    wdata_i,
  input logic             irq_o,
  input logic [CFG_W-1:0] cfg_q,
  input logic             locked_q,
  input logic             en_q,
  input logic             f2_q,
  input logic             tick,
  input logic [DW-1:0]    cnt_q
);
  logic set_wr, cnt_wr;
  assign set_wr = req_i & we_i & (addr_i == AW'(4'hE));
  assign cnt_wr = req_i & we_i & (addr_i == AW'(4'hC));

  // R3
  lock_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr |=> locked_q);
  // R4
  cfg_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> $stable(cfg_q));
  // R5
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !cnt_wr) |=> $stable(cnt_q));
  // R7
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_wr && cnt_q == '1) |=> (cnt_q == '0));
  // R10
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_wr && wdata_i[14]) |=> !f2_q);
  // R9
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !(set_wr && wdata_i[14])) |=> irq_o);
endmodule

bind tmr_channel tmr_channel_chk #(.DW(DW), .AW(AW), .CFG_W(tmr_pkg::CFG_W)) i_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .irq_o,
  .cfg_q, .locked_q, .en_q, .f2_q, .tick, .cnt_q
);

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        slow_tick_i = 1'b0, fast_tick_i = 1'b1;
  logic        irq_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  tmr_channel i_tmr_channel (.*);

  always #2 clk_i = ~clk_i;

  // slow source: one pulse every 4 clocks
  int slow_div = 0;
  always @(negedge clk_i) begin
    slow_div    = (slow_div + 1) % 4;
    slow_tick_i <= (slow_div == 0);
  end

  // behavioural reference model
  logic [15:0] m_cmp, m_cnt, m_rd;
  logic [11:0] m_cfg;
  bit m_lock, m_en, m_f1, m_f2;
  int m_pre;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cmp = 0; m_cnt = 0; m_rd = 0; m_cfg = 0;
      m_lock = 0; m_en = 0; m_f1 = 0; m_f2 = 0; m_pre = 0;
    end else begin
      bit src, tck, ev, swr;
      int mask, mode;
      src  = m_cfg[4] ? fast_tick_i : slow_tick_i;
      mask = (1 << m_cfg[3:0]) - 1;
      tck  = m_en && src && ((m_pre & mask) == mask);
      mode = m_cfg[9:8];
      ev   = m_en && ((mode == 1 && m_cnt == m_cmp) || (mode >= 2 && m_cnt >= m_cmp));
      swr  = req_i && we_i && addr_i == 4'hE;
      if (req_i && !we_i)
        case (addr_i)
          4'hA: m_rd = m_cmp;
          4'hC: m_rd = m_cnt;
          4'hE: m_rd = {m_en, m_f2, m_f1, m_lock, m_cfg};
          default: m_rd = 0;
        endcase
      if (!m_en) m_pre = 0; else if (src) m_pre = (m_pre + 1) % 32768;
      if (swr && wdata_i[14]) m_f2 = 0; else if (ev) m_f2 = 1;
      if (swr && wdata_i[13]) m_f1 = 0;
      if (swr) m_en = wdata_i[15];
      if (swr && !m_lock) begin m_cfg = wdata_i[11:0]; m_lock = 1; end
      if (req_i && we_i && addr_i == 4'hC) m_cnt = wdata_i;
      else if (tck) m_cnt = m_cnt + 16'd1;
      if (req_i && we_i && addr_i == 4'hA) m_cmp = wdata_i;
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // R9: interrupt compared with the model on every clock
  always @(negedge clk_i)
    if (rst_ni && !done) check("R9", {15'd0, irq_o}, {15'd0, m_f2 && m_cfg[9:8] == 2'b11});

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(string tag, logic [3:0] a, output logic [15:0] v);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i);
    req_i = 0;
    v = rdata_o;
    check(tag, rdata_o, m_rd);
  endtask

  task automatic reset();
    @(negedge clk_i);
    rst_ni = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v, v2;
    reset();
    // R1 reset state
    rd("R1", 4'hA, v); check("R1", v, 16'h0000);
    rd("R1", 4'hC, v); check("R1", v, 16'h0000);
    rd("R1", 4'hE, v); check("R1", v, 16'h0000);
    check("R1", {15'd0, irq_o}, 16'h0000);

    // R2 register readback, unmapped offset
    wr(4'hA, 16'h1234); wr(4'hC, 16'hBEEF);
    rd("R2", 4'hA, v); check("R2", v, 16'h1234);
    rd("R2", 4'hC, v); check("R2", v, 16'hBEEF);
    rd("R2", 4'h4, v); check("R2", v, 16'h0000);

    // R3/R4 lock: scale 3, slow, mode 11
    wr(4'hA, 16'd5); wr(4'hC, 16'd0);
    wr(4'hE, 16'h0303);
    rd("R3", 4'hE, v); check("R3", v, 16'h1303);
    wr(4'hE, 16'h0010); // new cfg must be ignored, enable stays 0
    rd("R4", 4'hE, v); check("R4", v, 16'h1303);

    // R5 held while disabled
    idle(40);
    rd("R5", 4'hC, v); check("R5", v, 16'h0000);

    // R6 prescale 8 on slow ticks, R8/R9 GE + irq
    wr(4'hE, 16'h8000);
    idle(64);
    rd("R6", 4'hC, v);
    for (int i = 0; i < 400 && !irq_o; i++) idle(1);
    check("R9", {15'd0, irq_o}, 16'h0001);
    rd("R8", 4'hE, v); check("R8", v & 16'h4000, 16'h4000);

    // R10 write-0 leaves flag; irq stays up
    wr(4'hE, 16'h8000);
    rd("R10", 4'hE, v); check("R10", v & 16'h4000, 16'h4000);
    check("R9", {15'd0, irq_o}, 16'h0001);

    // R11 clear-and-stop
    wr(4'hE, 16'h6000);
    idle(2);
    check("R11", {15'd0, irq_o}, 16'h0000);
    rd("R11", 4'hC, v); idle(64); rd("R11", 4'hC, v2); check("R11", v2, v);
    rd("R11", 4'hE, v); check("R11", v, 16'h1303);

    // R7 wrap, R6 fast source scale 0, R8 equality mode
    reset();
    wr(4'hA, 16'd3);
    wr(4'hE, 16'h0110);
    wr(4'hC, 16'hFFFE);
    wr(4'hE, 16'h8000);
    idle(3);
    rd("R7", 4'hC, v);
    idle(10);
    rd("R8", 4'hE, v); check("R8", v & 16'h4000, 16'h4000);
    check("R9", {15'd0, irq_o}, 16'h0000);
    // R10: clear while enabled and counter past compare (eq no longer true)
    wr(4'hE, 16'hC000);
    rd("R10", 4'hE, v); check("R10", v & 16'h4000, 16'h0000);
    // R2 counter write beats increment while running
    wr(4'hC, 16'h0100);
    rd("R2", 4'hC, v);

    // R8 mode 00: no event
    reset();
    wr(4'hA, 16'd0);
    wr(4'hE, 16'h8010);
    idle(20);
    rd("R8", 4'hE, v); check("R8", v & 16'h4000, 16'h0000);
    rd("R6", 4'hC, v);

    // R8/R9 mode 10: flag without interrupt
    reset();
    wr(4'hA, 16'd2);
    wr(4'hE, 16'h8210);
    idle(20);
    rd("R8", 4'hE, v); check("R8", v & 16'h4000, 16'h4000);
    check("R9", {15'd0, irq_o}, 16'h0000);

    done = 1;
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule